// File: doc/BRIEF.md
# Failover Clock Switch Controller

This block produces one output clock from two sources: a monitored oscillator clock and an always-running, already prescaled safe clock. After reset the oscillator drives the output. When the failure indication from an external activity monitor rises, the block moves the output to the safe clock on its own initiative, so that downstream logic keeps a clock while the oscillator is dead. The oscillator itself is never powered down here; software keeps that duty.

Return to the oscillator is never automatic. Software writes a one to a switch-back bit. The bit is held until the failure indication has gone low, then the output moves back and hardware clears the bit. While the safe clock drives the output, failure events from the monitor are blocked, and a ready flag reports whether the safe source is stable. Every control and status signal lives in the safe clock domain. The output multiplexer is glitch-free: each branch enable is retimed on the falling edge of its own clock, and a branch is only enabled once the other branch reports itself off.

Top module: `failover_clk_switch`

## Requirements
- R1: After reset the switched, ready and switch-back outputs are 0, and within a few oscillator cycles the output clock follows the oscillator (high after each oscillator rising edge, low after each falling edge).
- R2: When the failure input rises and the oscillator has stopped, the switched output goes to 1 between 3 and 7 safe-clock cycles later, and from then on the output clock follows the safe clock.
- R3: The switched output is 1 exactly while the safe clock is, or is being kept as, the output source. It is set once the safe branch is active and cleared once the oscillator branch is active again.
- R4: The ready output is 1 only while switched is 1 and the safe-stable input (synchronized) is 1. Ready is 0 while switched is 0.
- R5: Switching back never happens without a switch-back write. A write made while failure is still 1 is held, with the output staying on the safe clock, and takes effect after failure returns to 0.
- R6: When the output is back on the oscillator, hardware clears the switch-back bit in the same cycle as the switched bit, and the output clock follows the oscillator again.
- R7: A switch-back write while switched is 0 is ignored, and the switch-back bit stays 0.
- R8: The event output passes the raw failure event while the oscillator is selected and is held at 0 while switched is 1.
- R9: No high or low phase of the output clock is shorter than the shorter half-period of the two sources, across reset, failover and switch-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Monitored oscillator clock |
| safe_clk | input | 1 | Prescaled safe clock; clocks all control logic |
| fail_i | input | 1 | Failure level from the activity monitor (synchronized inside) |
| swb_wr_i | input | 1 | One-cycle software write of one to the switch-back bit, safe domain |
| safe_stable_i | input | 1 | Safe source stable indication (synchronized inside) |
| fail_evt_i | input | 1 | Raw failure event pulse, safe domain |
| clk_o | output | 1 | Glitch-free output clock |
| switched_o | output | 1 | Output is on the safe clock |
| ready_o | output | 1 | Safe clock selected and stable |
| swb_o | output | 1 | Switch-back bit; cleared by hardware on return |
| evt_o | output | 1 | Failure event, blocked while switched |

## Verification
A controller stuck in a transit state shows at the ports within about ten safe cycles. Either switched never rises after a failure, or it never falls after a valid switch-back, and the output clock then keeps tracking the wrong source when it is sampled one nanosecond after each source edge. A branch enable that is wrong or retimed on the wrong edge shows as a runt phase on the output clock, which the pulse-width monitor catches on the first transition. Bad bookkeeping of the switch-back bit shows in the cycle right after the write, or in the cycle of return, as a mismatch between swb_o and switched_o.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
  typedef enum logic [1:0] {
    ST_OSC     = 2'd0,
    ST_TO_SAFE = 2'd1,
    ST_SAFE    = 2'd2,
    ST_TO_OSC  = 2'd3
  } fcs_state_e;
endpackage

// File: rtl/fcs_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer, rising-edge.
module fcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fcs_gate_branch.sv
`timescale 1ns/1ps
// One branch of the glitch-free mux: the enable request is retimed on the
// falling edge of the branch clock, so the gate only opens or closes while
// that clock is low. clr_n forces the branch off at once.
module fcs_gate_branch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic req,
  output logic en
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(negedge clk or negedge clr_n)
          if (!clr_n) chain[0] <= 1'b0;
          else        chain[0] <= req;
      end else begin : g_next
        always_ff @(negedge clk or negedge clr_n)
          if (!clr_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign en = chain[STAGES-1];
endmodule

// File: rtl/fcs_ctrl.sv
`timescale 1ns/1ps
// Selection state machine in the safe clock domain.
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fail_s,
  input  logic stable_s,
  input  logic swb_wr,
  input  logic fail_evt,
  input  logic safe_on,
  input  logic osc_on,
  output logic want_safe,
  output logic switched,
  output logic ready,
  output logic swb,
  output logic evt_out
);
  fcs_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OSC;
      want_safe <= 1'b0;
      switched  <= 1'b0;
      ready     <= 1'b0;
      swb       <= 1'b0;
    end else begin
      ready <= (state == ST_SAFE) && stable_s;
      if (swb_wr && switched) swb <= 1'b1;
      unique case (state)
        ST_OSC: begin
          if (fail_s) begin
            want_safe <= 1'b1;
            state     <= ST_TO_SAFE;
          end
        end
        ST_TO_SAFE: begin
          if (safe_on) begin
            switched <= 1'b1;
            state    <= ST_SAFE;
          end
        end
        ST_SAFE: begin
          if (swb && !fail_s) begin
            want_safe <= 1'b0;
            state     <= ST_TO_OSC;
          end
        end
        ST_TO_OSC: begin
          if (fail_s) begin
            want_safe <= 1'b1;
            state     <= ST_TO_SAFE;
          end else if (osc_on) begin
            switched <= 1'b0;
            swb      <= 1'b0;
            state    <= ST_OSC;
          end
        end
        default: state <= ST_OSC;
      endcase
    end
  end

  assign evt_out = fail_evt && (state == ST_OSC);
endmodule

// File: rtl/failover_clk_switch.sv
`timescale 1ns/1ps
module failover_clk_switch #(
  parameter int SYNC_STAGES = 2,
  parameter int GATE_STAGES = 2
) (
  input  logic rst_n,
  input  logic osc_clk,
  input  logic safe_clk,
  input  logic fail_i,
  input  logic swb_wr_i,
  input  logic safe_stable_i,
  input  logic fail_evt_i,
  output logic clk_o,
  output logic switched_o,
  output logic ready_o,
  output logic swb_o,
  output logic evt_o
);
  logic fail_s, stable_s, osc_on_s;
  logic want_safe, osc_en, safe_en, osc_clr_n;

  fcs_sync #(.STAGES(SYNC_STAGES)) u_fail_sync (
    .clk(safe_clk), .rst_n(rst_n), .d(fail_i), .q(fail_s));
  fcs_sync #(.STAGES(SYNC_STAGES)) u_stable_sync (
    .clk(safe_clk), .rst_n(rst_n), .d(safe_stable_i), .q(stable_s));
  fcs_sync #(.STAGES(SYNC_STAGES)) u_osc_on_sync (
    .clk(safe_clk), .rst_n(rst_n), .d(osc_en), .q(osc_on_s));

  // The oscillator may be dead when the safe clock is wanted, so its branch
  // is cleared directly rather than waiting for a falling edge of its own.
  assign osc_clr_n = rst_n & ~want_safe;

  fcs_gate_branch #(.STAGES(GATE_STAGES)) u_osc_branch (
    .clk(osc_clk), .clr_n(osc_clr_n),
    .req(~want_safe & ~safe_en), .en(osc_en));
  fcs_gate_branch #(.STAGES(GATE_STAGES)) u_safe_branch (
    .clk(safe_clk), .clr_n(rst_n),
    .req(want_safe & ~osc_en), .en(safe_en));

  assign clk_o = (osc_clk & osc_en) | (safe_clk & safe_en);

  fcs_ctrl u_ctrl (
    .clk(safe_clk), .rst_n(rst_n), .fail_s(fail_s), .stable_s(stable_s),
    .swb_wr(swb_wr_i), .fail_evt(fail_evt_i), .safe_on(safe_en),
    .osc_on(osc_on_s), .want_safe(want_safe), .switched(switched_o),
    .ready(ready_o), .swb(swb_o), .evt_out(evt_o));
endmodule

// File: rtl/fcs_checks.sv
`timescale 1ns/1ps
module fcs_checks (
  input logic clk,
  input logic rst_n,
  input logic switched,
  input logic ready,
  input logic swb,
  input logic evt
);
  // R4: ready never without the switched status
  assert_ready_needs_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> switched);
  // R8: events blocked while on the safe clock
  assert_evt_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    switched |-> !evt);
  // R7: the switch-back bit only exists while switched
  assert_swb_needs_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swb |-> switched);
  // R6: return clears the switch-back bit in the same cycle
  assert_swb_clears_on_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(switched) |-> $fell(swb));
endmodule

bind failover_clk_switch fcs_checks u_chk (
  .clk(safe_clk), .rst_n(rst_n), .switched(switched_o),
  .ready(ready_o), .swb(swb_o), .evt(evt_o));

// File: tb/sim_failover_clk_switch.sv
`timescale 1ns/1ps
module sim_failover_clk_switch;
  logic rst_n = 0, osc_clk = 0, safe_clk = 0;
  logic fail_i = 0, swb_wr_i = 0, safe_stable_i = 0, fail_evt_i = 0;
  logic clk_o, switched_o, ready_o, swb_o, evt_o;
  bit   osc_run = 1;
  int   errors = 0, checks = 0;
  bit   mon_on = 0;
  realtime last_t = -1.0, min_w = 1000.0;

  failover_clk_switch u0 (
    .rst_n(rst_n), .osc_clk(osc_clk), .safe_clk(safe_clk), .fail_i(fail_i),
    .swb_wr_i(swb_wr_i), .safe_stable_i(safe_stable_i), .fail_evt_i(fail_evt_i),
    .clk_o(clk_o), .switched_o(switched_o), .ready_o(ready_o),
    .swb_o(swb_o), .evt_o(evt_o));

  always #2 safe_clk = ~safe_clk;               // 250 MHz
  always begin #3; if (osc_run) osc_clk = ~osc_clk; end

  always @(clk_o) if (mon_on) begin
    if (last_t >= 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic follow(input bit on_osc, output int bad);
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      if (on_osc) @(posedge osc_clk); else @(posedge safe_clk);
      #1 if (clk_o !== 1'b1) bad++;
      if (on_osc) @(negedge osc_clk); else @(negedge safe_clk);
      #1 if (clk_o !== 1'b0) bad++;
    end
  endtask

  task automatic pulse_swb();
    @(negedge safe_clk) swb_wr_i = 1;
    @(negedge safe_clk) swb_wr_i = 0;
  endtask

  task automatic scenario(input bit lvl, input bit stab, input bit early);
    int bad, n;
    rst_n = 0; fail_i = 0; swb_wr_i = 0; fail_evt_i = 0;
    safe_stable_i = stab; osc_run = 1; mon_on = 0;
    repeat (3) @(negedge safe_clk);
    rst_n = 1;
    repeat (2) @(negedge safe_clk);
    chk(!switched_o && !ready_o && !swb_o, "R1 reset status",
        {switched_o, ready_o, swb_o}, 0);
    repeat (4) @(negedge safe_clk);
    follow(1, bad); chk(bad == 0, "R1 follows oscillator", bad, 0);
    last_t = -1.0; min_w = 1000.0; mon_on = 1;

    @(negedge safe_clk) fail_evt_i = 1;
    #1 chk(evt_o === 1'b1, "R8 event passed on oscillator", evt_o, 1);
    @(negedge safe_clk) fail_evt_i = 0;

    pulse_swb();
    repeat (3) @(negedge safe_clk);
    chk(!swb_o && !switched_o, "R7 write ignored on oscillator", swb_o, 0);

    // stop the oscillator at the chosen level
    while (osc_clk !== lvl) @(osc_clk);
    #1 osc_run = 0;
    repeat (4) @(negedge safe_clk);
    fail_i = 1; n = 0;
    while (!switched_o && n < 20) begin @(negedge safe_clk); n++; end
    chk(n >= 3 && n <= 7, "R2 R3 switch latency", n, 5);
    follow(0, bad); chk(bad == 0, "R2 follows safe clock", bad, 0);

    repeat (2) @(negedge safe_clk);
    chk(ready_o == stab, "R4 ready vs stable", ready_o, stab);
    if (!stab) begin
      safe_stable_i = 1;
      repeat (4) @(negedge safe_clk);
      chk(ready_o == 1'b1, "R4 ready after stable", ready_o, 1);
    end

    @(negedge safe_clk) fail_evt_i = 1;
    #1 chk(evt_o === 1'b0, "R8 event blocked on safe", evt_o, 0);
    @(negedge safe_clk) fail_evt_i = 0;

    osc_run = 1;
    if (early) begin
      pulse_swb();
      repeat (20) @(negedge safe_clk);
      chk(switched_o && swb_o, "R5 request held during failure",
          {switched_o, swb_o}, 3);
      follow(0, bad); chk(bad == 0, "R5 stays on safe clock", bad, 0);
      @(negedge safe_clk) fail_i = 0;
    end else begin
      @(negedge safe_clk) fail_i = 0;
      repeat (20) @(negedge safe_clk);
      chk(switched_o && !swb_o, "R5 no return without request",
          {switched_o, swb_o}, 2);
      pulse_swb();
      chk(swb_o === 1'b1, "R5 request accepted", swb_o, 1);
    end
    n = 0;
    while (switched_o && n < 60) begin @(negedge safe_clk); n++; end
    chk(!switched_o, "R3 R6 switched cleared on return", switched_o, 0);
    chk(!swb_o, "R6 switch-back bit cleared", swb_o, 0);
    chk(!ready_o, "R4 ready low after return", ready_o, 0);
    follow(1, bad); chk(bad == 0, "R6 follows oscillator again", bad, 0);
    mon_on = 0;
    chk(min_w >= 1.5, "R9 narrowest output phase ps", int'(min_w * 1000.0), 2000);
  endtask

  initial begin
    for (int lvl = 0; lvl < 2; lvl++)
      for (int st = 0; st < 2; st++)
        for (int e = 0; e < 2; e++)
          scenario(lvl[0], st[0], e[0]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge safe_clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule